// File: doc/BRIEF.md
# UART Baud Rate Generator with Reserved High-Speed Divisors

The block turns a system clock into the two timing strobes a UART needs. A one-cycle sample tick marks each oversampling point. A one-cycle bit tick marks each bit boundary. Software sets the rate with a 16-bit divisor, written as two separate bytes. It can also place a 13/8 fractional prescaler in front of the divider. With that prescaler on, the input clock looks 1.625 times slower.

An ordinary divisor N gives one sample tick every N prescaled enables and one bit tick every 16 sample ticks. The baud rate is therefore f/(16·N). Two divisor codes with the top bit set are reserved and select faster rates:

- 0x8001 gives f/4.
- 0x8002 gives f/8.

For both codes a sample tick comes on every enable, and the bit tick comes after 4 or 8 of them. Every other divisor value, including other codes with bit 15 set, is an ordinary divisor. Zero counts as 65536. A write to either divisor byte restarts all counting, so the new rate begins from a clean phase.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is asserted both tick outputs are low, and the divisor resets to 1. After release, sample ticks therefore arrive on every cycle with the prescaler off.
- R2: For an ordinary divisor N, sample_tick_o pulses once every N prescaled enables. The first pulse appears in cycle N after a restart (cycle 0 is the cycle following the write edge).
- R3: For ordinary divisors, bit_tick_o pulses together with every 16th sample tick counted from a restart, and bit_tick_o is never high without sample_tick_o.
- R4: A divisor of 0 behaves as 65536: the first sample tick after a restart comes in cycle 65536.
- R5: Divisor 0x8001 gives a sample tick on every prescaled enable and a bit tick on every 4th sample tick.
- R6: Divisor 0x8002 gives a sample tick on every prescaled enable and a bit tick on every 8th sample tick.
- R7: A divisor with bit 15 set other than 0x8001 and 0x8002 is an ordinary divisor of that value.
- R8: A write with div_lo_we_i replaces bits 7:0 of the divisor and a write with div_hi_we_i replaces bits 15:8. The other byte keeps its value.
- R9: A write to either byte clears the prescaler and all counters at that clock edge. Both ticks are low in cycle 0, and the following ticks are timed from that edge.
- R10: With presc_sel_i = 1 the prescaler produces 8 enables per 13 cycles. Counting cycles c from a restart, cycle c carries an enable exactly when floor(8(c+1)/13) > floor(8c/13). Three consecutive enables never occur.
- R11: With presc_sel_i = 0 every cycle carries an enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_lo_we_i | input | 1 | Write strobe for divisor bits 7:0 |
| div_hi_we_i | input | 1 | Write strobe for divisor bits 15:8 |
| div_wdata_i | input | 8 | Byte written to the selected divisor half |
| presc_sel_i | input | 1 | 0: no prescale; 1: divide by 1.625 (13/8) |
| sample_tick_o | output | 1 | Oversampling strobe, one cycle wide |
| bit_tick_o | output | 1 | Bit boundary strobe, one cycle wide |

## Verification
Both ticks are registered, so an enable counted in cycle j-1 shows up on the outputs in cycle j. The last write edge opens cycle 0, in which both outputs must be low. The bench derives, from the enable count in cycle j-1, whether each output is due in cycle j. It computes that count arithmetically as floor(8(c+1)/13) or c+1. Every output is sampled at the falling edge, one half period away from the edge that updates it, and compared in every cycle of each window.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  typedef enum logic [1:0] {
    RATE_ORDINARY = 2'd0,
    RATE_FAST_X4  = 2'd1,
    RATE_FAST_X8  = 2'd2
  } rate_mode_e;

  localparam int unsigned PRESC_NUM   = 8;
  localparam int unsigned PRESC_DEN   = 13;
  localparam int unsigned OS_W        = 4;
  localparam int unsigned OS_ORDINARY = 16;
  localparam int unsigned OS_FAST_X4  = 4;
  localparam int unsigned OS_FAST_X8  = 8;
endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg
  import uart_baud_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned RESET_DIV = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lo_we_i,
  input  logic                     hi_we_i,
  input  logic [7:0]               wdata_i,
  output logic                     restart_o,
  output rate_mode_e               mode_o,
  output logic [DIV_W-1:0]         period_m1_o,
  output logic [OS_W-1:0]          os_m1_o
);
  localparam int unsigned HI_W = DIV_W - 8;
  localparam logic [DIV_W-1:0] CODE_X4 = {1'b1, {(DIV_W-3){1'b0}}, 2'b01};
  localparam logic [DIV_W-1:0] CODE_X8 = {1'b1, {(DIV_W-3){1'b0}}, 2'b10};

  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q;
    if (lo_we_i) div_d[7:0]       = wdata_i;
    if (hi_we_i) div_d[DIV_W-1:8] = wdata_i[HI_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   div_q <= DIV_W'(RESET_DIV);
    else if (lo_we_i || hi_we_i)   div_q <= div_d;
  end

  assign restart_o = lo_we_i | hi_we_i;

  always_comb begin
    mode_o      = RATE_ORDINARY;
    period_m1_o = div_q - 1'b1;
    os_m1_o     = OS_W'(OS_ORDINARY - 1);
    if (div_q == CODE_X4) begin
      mode_o      = RATE_FAST_X4;
      period_m1_o = '0;
      os_m1_o     = OS_W'(OS_FAST_X4 - 1);
    end else if (div_q == CODE_X8) begin
      mode_o      = RATE_FAST_X8;
      period_m1_o = '0;
      os_m1_o     = OS_W'(OS_FAST_X8 - 1);
    end
  end
endmodule

// File: rtl/baud_frac_presc.sv
module baud_frac_presc #(
  parameter int unsigned NUM = 8,
  parameter int unsigned DEN = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic frac_en_i,
  output logic pre_en_o
);
  localparam int unsigned ACC_W = $clog2(DEN + NUM) + 1;

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             wrap;

  always_comb begin
    sum   = acc_q + ACC_W'(NUM);
    wrap  = (sum >= ACC_W'(DEN));
    acc_d = acc_q;
    if (clr_i || !frac_en_i) acc_d = '0;
    else if (wrap)           acc_d = sum - ACC_W'(DEN);
    else                     acc_d = sum;
  end

  assign pre_en_o = !frac_en_i || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import uart_baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pre_en_i,
  input  logic [DIV_W-1:0] period_m1_i,
  input  logic [OS_W-1:0]  os_m1_i,
  output logic             sample_tick_o,
  output logic             bit_tick_o
);
  logic [DIV_W-1:0] scnt_q, scnt_d;
  logic [OS_W-1:0]  ocnt_q, ocnt_d;
  logic             samp, last_os;
  logic             samp_q, bit_q;

  always_comb begin
    samp    = pre_en_i && (scnt_q == period_m1_i);
    last_os = (ocnt_q == os_m1_i);
    scnt_d  = scnt_q;
    ocnt_d  = ocnt_q;
    if (pre_en_i) scnt_d = samp ? '0 : scnt_q + 1'b1;
    if (samp)     ocnt_d = last_os ? '0 : ocnt_q + 1'b1;
    if (clr_i) begin
      scnt_d = '0;
      ocnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scnt_q <= '0;
      ocnt_q <= '0;
      samp_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      scnt_q <= scnt_d;
      ocnt_q <= ocnt_d;
      samp_q <= samp && !clr_i;
      bit_q  <= samp && last_os && !clr_i;
    end
  end

  assign sample_tick_o = samp_q;
  assign bit_tick_o    = bit_q;
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned RESET_DIV = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       div_lo_we_i,
  input  logic       div_hi_we_i,
  input  logic [7:0] div_wdata_i,
  input  logic       presc_sel_i,
  output logic       sample_tick_o,
  output logic       bit_tick_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             restart;
  rate_mode_e       mode;
  logic [DIV_W-1:0] period_m1;
  logic [OS_W-1:0]  os_m1;
  logic             pre_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  baud_div_reg #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .lo_we_i     (div_lo_we_i),
    .hi_we_i     (div_hi_we_i),
    .wdata_i     (div_wdata_i),
    .restart_o   (restart),
    .mode_o      (mode),
    .period_m1_o (period_m1),
    .os_m1_o     (os_m1)
  );

  baud_frac_presc #(.NUM(PRESC_NUM), .DEN(PRESC_DEN)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .clr_i     (restart),
    .frac_en_i (presc_sel_i),
    .pre_en_o  (pre_en)
  );

  baud_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_int),
    .clr_i         (restart),
    .pre_en_i      (pre_en),
    .period_m1_i   (period_m1),
    .os_m1_i       (os_m1),
    .sample_tick_o (sample_tick_o),
    .bit_tick_o    (bit_tick_o)
  );
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic div_lo_we_i,
  input logic div_hi_we_i,
  input logic presc_sel_i,
  input logic sample_tick_o,
  input logic bit_tick_o
);
  // R3
  bit_with_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);

  // R9
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_lo_we_i || div_hi_we_i) |=> (!sample_tick_o && !bit_tick_o));

  // R5
  bit_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);

  // R10
  frac_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(presc_sel_i, 1) && $past(presc_sel_i, 2) && $past(presc_sel_i, 3)
     && sample_tick_o && $past(sample_tick_o))
    |-> !$past(sample_tick_o, 2));
endmodule

bind uart_baud_gen uart_baud_gen_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .div_lo_we_i   (div_lo_we_i),
  .div_hi_we_i   (div_hi_we_i),
  .presc_sel_i   (presc_sel_i),
  .sample_tick_o (sample_tick_o),
  .bit_tick_o    (bit_tick_o)
);

// File: tb/uart_baud_gen_tb_top.sv
`timescale 1ns/1ps
module uart_baud_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lo_we, hi_we, presc;
  logic [7:0] wdata;
  logic       samp, bitt;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  uart_baud_gen dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .div_lo_we_i   (lo_we),
    .div_hi_we_i   (hi_we),
    .div_wdata_i   (wdata),
    .presc_sel_i   (presc),
    .sample_tick_o (samp),
    .bit_tick_o    (bitt)
  );

  function automatic longint pre_cnt(longint c, bit fr);
    if (c < 0) return 0;
    return fr ? (8 * (c + 1)) / 13 : c + 1;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic wr(bit hi, logic [7:0] d);
    @(negedge clk);
    lo_we = !hi; hi_we = hi; wdata = d;
    @(negedge clk);
    lo_we = 1'b0; hi_we = 1'b0;
  endtask

  // Observes cycles 0..w-1 after the last write edge.
  task automatic run(string req, longint p, longint r, bit fr, longint w);
    for (longint j = 0; j < w; j++) begin
      logic es, eb;
      es = 1'b0; eb = 1'b0;
      if (j > 0) begin
        longint k;
        k  = pre_cnt(j - 1, fr);
        es = (k != pre_cnt(j - 2, fr)) && (k % p == 0);
        eb = es && ((k / p) % r == 0);
      end
      chk({req, " R9 sample"}, samp, es);
      chk({req, " R3 bit"}, bitt, eb);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lo_we = 1'b0; hi_we = 1'b0; wdata = '0; presc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset sample", samp, 1'b0);
    chk("R1 reset bit", bitt, 1'b0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk("R1 reset divisor 1", samp, 1'b1);
      @(negedge clk);
    end
    // R2 R11 ordinary divisor 3
    wr(1'b1, 8'h00); wr(1'b0, 8'd3);
    run("R2 R11 div3", 3, 16, 1'b0, 120);
    // R8 low byte only
    wr(1'b0, 8'd5);
    run("R8 div5", 5, 16, 1'b0, 200);
    // R10 fractional prescaler
    presc = 1'b1;
    wr(1'b0, 8'd5);
    run("R10 div5 frac", 5, 16, 1'b1, 200);
    // R7 high byte only gives 0x8005, ordinary
    presc = 1'b0;
    wr(1'b1, 8'h80);
    run("R7 R8 0x8005", 32773, 16, 1'b0, 300);
    // R5
    wr(1'b0, 8'h01);
    run("R5 0x8001", 1, 4, 1'b0, 60);
    presc = 1'b1;
    wr(1'b0, 8'h01);
    run("R5 R10 0x8001 frac", 1, 4, 1'b1, 60);
    // R6
    presc = 1'b0;
    wr(1'b0, 8'h02);
    run("R6 0x8002", 1, 8, 1'b0, 60);
    presc = 1'b1;
    wr(1'b0, 8'h02);
    run("R6 R10 0x8002 frac", 1, 8, 1'b1, 80);
    // R2 ordinary 1 and 2
    presc = 1'b0;
    wr(1'b1, 8'h00);
    run("R2 div2", 2, 16, 1'b0, 80);
    wr(1'b0, 8'h01);
    run("R2 div1", 1, 16, 1'b0, 60);
    presc = 1'b1;
    wr(1'b0, 8'h02);
    run("R2 R10 div2 frac", 2, 16, 1'b1, 120);
    // R9 restart mid-run, then R4 divisor zero
    presc = 1'b0;
    wr(1'b0, 8'h03);
    repeat (7) @(negedge clk);
    wr(1'b0, 8'h03);
    run("R9 restart div3", 3, 16, 1'b0, 60);
    wr(1'b0, 8'h00);
    run("R4 div0", 65536, 16, 1'b0, 65540);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule